// File: doc/BRIEF.md
# Differential Bus Receive Qualifier

This block sits behind the four threshold comparators of a differential bus receiver and produces the single-ended receive data line handed to the communication controller. The comparators flag a differential voltage above the positive activity level, below the negative activity level, above the logic-one data level and below the logic-zero data level. The block re-times these flags into the core clock, then qualifies them over time. Activity is declared only after one of the activity flags has been held for a programmable number of cycles. Idle is declared only after both activity flags have been clear for a separate, independently programmable number of cycles.

While the bus is active, the receive line follows the data comparators and keeps its level when the voltage sits between the two data levels. While the bus is idle, or whenever the transceiver is not in its full-power operating mode, the receive line is parked high and the detected bus state reads idle. Filter lengths are given in clock cycles. A fast clock of around 100 MHz is assumed, so that the data path keeps up with bits as short as about 54 ns.

Top module: `bus_rx_qualifier`

## Requirements
- R1: After reset, with `op_normal` high and `cmp_pos_act` or `cmp_neg_act` held high continuously, `bus_busy` rises exactly SYNC_STAGES + ACT_CYCLES rising clock edges after the input change.
- R2: A burst of activity flags shorter than ACT_CYCLES consecutive cycles never sets `bus_busy` and never pulls `rx_data` low; the activity count restarts whenever both activity flags drop.
- R3: With the bus busy, once both activity flags are clear, `bus_busy` falls and `rx_data` is 1 exactly SYNC_STAGES + IDLE_CYCLES edges after the input change.
- R4: A quiet gap shorter than IDLE_CYCLES consecutive cycles inside activity leaves `bus_busy` high and `rx_data` unchanged.
- R5: While the bus is busy, `cmp_one` high drives `rx_data` to 1 and `cmp_zero` high drives it to 0, SYNC_STAGES + 1 edges after the input change, so a data bit lasting a single clock cycle is reproduced. If both are high, `cmp_one` wins.
- R6: While the bus is busy and neither data comparator is high, `rx_data` keeps its last value.
- R7: With `op_normal` low, `rx_data` is 1 and `bus_busy` is 0 from the next edge on, whatever the comparator inputs.
- R8: Reset (`rst_n` low) gives `rx_data` = 1 and `bus_busy` = 0.
- R9: While the bus is idle, the data comparators have no effect: `rx_data` stays 1 even with `cmp_zero` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_normal | input | 1 | High while the transceiver is in its full-power operating mode |
| cmp_pos_act | input | 1 | Differential voltage above the positive activity level (asynchronous) |
| cmp_neg_act | input | 1 | Differential voltage below the negative activity level (asynchronous) |
| cmp_one | input | 1 | Differential voltage above the logic-one data level (asynchronous) |
| cmp_zero | input | 1 | Differential voltage below the logic-zero data level (asynchronous) |
| rx_data | output | 1 | Qualified receive data, high when idle |
| bus_busy | output | 1 | Detected bus state: 1 busy, 0 idle |

## Verification
Activity bursts of every length from one cycle to two beyond the activity window are swept. This separates a filter that counts consecutive cycles from one that accumulates or fires early. Quiet gaps are swept in the same way across the idle window, which shows whether the idle count is independent of the activity count. A per-cycle alternating data pattern measures the data latency exactly and exposes any extra filtering on the data path. Mode-low runs with a live bus, and idle-bus runs with the zero comparator asserted, confirm that the output stays parked high.

// File: rtl/brx_pkg.sv
package brx_pkg;
   typedef enum logic {
      LINK_QUIET = 1'b0,
      LINK_BUSY  = 1'b1
   } link_state_t;

   localparam int unsigned CMP_POS  = 0;
   localparam int unsigned CMP_NEG  = 1;
   localparam int unsigned CMP_ONE  = 2;
   localparam int unsigned CMP_ZERO = 3;
   localparam int unsigned CMP_W    = 4;
endpackage

// File: rtl/brx_sync.sv
module brx_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   initial begin
      assert (WIDTH >= 1) else $error("brx_sync: WIDTH must be at least 1");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q[s] <= '0;
               end else begin
                  if (s == 0) stage_q[s] <= async_in;
                  else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign sync_out = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/brx_qual_timer.sv
module brx_qual_timer #(
   parameter int unsigned LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_off,
   input  logic cond,
   output logic expired
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   initial begin
      assert (LIMIT >= 1) else $error("brx_qual_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] run_q;

   assign expired = cond && !hold_off && (run_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (hold_off || !cond || expired) begin
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   // R2 / R4: the run counter never passes its terminal value
   p_run_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= LAST)
      else $error("run counter out of range");

   // R2 / R4: a dropped condition restarts the count
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cond |=> run_q == '0)
      else $error("run counter did not restart");
endmodule

// File: rtl/brx_data_path.sv
module brx_data_path (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_next,
   input  logic lvl_one,
   input  logic lvl_zero,
   output logic rx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= 1'b1;
      end else if (!busy_next) begin
         rx_q <= 1'b1;
      end else if (lvl_one) begin
         rx_q <= 1'b1;
      end else if (lvl_zero) begin
         rx_q <= 1'b0;
      end
   end

   // R6: between the data levels the output is kept
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_next && !lvl_one && !lvl_zero && $past(busy_next)) |=> $stable(rx_q))
      else $error("receive level not held in band");
endmodule

// File: rtl/bus_rx_qualifier.sv
module bus_rx_qualifier
   import brx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ACT_CYCLES  = 15,
   parameter int unsigned IDLE_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic op_normal,
   input  logic cmp_pos_act,
   input  logic cmp_neg_act,
   input  logic cmp_one,
   input  logic cmp_zero,
   output logic rx_data,
   output logic bus_busy
);
   initial begin
      assert (ACT_CYCLES >= 1)  else $error("ACT_CYCLES must be at least 1");
      assert (IDLE_CYCLES >= 1) else $error("IDLE_CYCLES must be at least 1");
   end

   logic [CMP_W-1:0] cmp_raw;
   logic [CMP_W-1:0] cmp_s;
   logic             act_s;
   logic             go_busy;
   logic             go_quiet;
   link_state_t      state_q;
   link_state_t      state_d;

   assign cmp_raw[CMP_POS]  = cmp_pos_act;
   assign cmp_raw[CMP_NEG]  = cmp_neg_act;
   assign cmp_raw[CMP_ONE]  = cmp_one;
   assign cmp_raw[CMP_ZERO] = cmp_zero;

   brx_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (cmp_raw),
      .sync_out (cmp_s)
   );

   assign act_s = cmp_s[CMP_POS] | cmp_s[CMP_NEG];

   brx_qual_timer #(.LIMIT(ACT_CYCLES)) u_act_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_off (!op_normal || (state_q == LINK_BUSY)),
      .cond     (act_s),
      .expired  (go_busy)
   );

   brx_qual_timer #(.LIMIT(IDLE_CYCLES)) u_idle_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_off (!op_normal || (state_q == LINK_QUIET)),
      .cond     (!act_s),
      .expired  (go_quiet)
   );

   always_comb begin
      state_d = state_q;
      if (!op_normal) begin
         state_d = LINK_QUIET;
      end else if (state_q == LINK_QUIET && go_busy) begin
         state_d = LINK_BUSY;
      end else if (state_q == LINK_BUSY && go_quiet) begin
         state_d = LINK_QUIET;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LINK_QUIET;
      else        state_q <= state_d;
   end

   brx_data_path u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_next (state_d == LINK_BUSY),
      .lvl_one   (cmp_s[CMP_ONE]),
      .lvl_zero  (cmp_s[CMP_ZERO]),
      .rx_q      (rx_data)
   );

   assign bus_busy = (state_q == LINK_BUSY);

   // R3 / R9: receive line parked high whenever the bus is idle
   p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_busy |-> rx_data)
      else $error("rx_data low while idle");

   // R1: becoming busy needs a qualifying activity flag
   p_busy_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_busy) |-> $past(act_s))
      else $error("busy without activity");

   // R3: returning to idle needs a quiet bus (in operating mode)
   p_quiet_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_busy) && $past(op_normal)) |-> !$past(act_s))
      else $error("idle while bus active");

   // R7: mode low parks the outputs on the next edge
   p_mode_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !op_normal |=> (rx_data && !bus_busy))
      else $error("outputs not parked outside operating mode");

   // R5: logic-one level drives the line high while busy
   p_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy && op_normal && act_s && cmp_s[CMP_ONE]) |=> rx_data)
      else $error("logic one not reproduced");

   // R5: logic-zero level drives the line low while busy
   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy && op_normal && act_s && cmp_s[CMP_ZERO] && !cmp_s[CMP_ONE]) |=> !rx_data)
      else $error("logic zero not reproduced");
endmodule

// File: tb/tb_bus_rx_qualifier.sv
`timescale 1ns/1ps
module tb_bus_rx_qualifier;
   localparam int SYNC = 2;
   localparam int ACT  = 4;
   localparam int IDLE = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_normal = 1'b0;
   logic pos_a = 1'b0, neg_a = 1'b0, one_l = 1'b0, zero_l = 1'b0;
   logic rx_data, bus_busy;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bus_rx_qualifier #(.SYNC_STAGES(SYNC), .ACT_CYCLES(ACT), .IDLE_CYCLES(IDLE)) dut (
      .clk(clk), .rst_n(rst_n), .op_normal(op_normal),
      .cmp_pos_act(pos_a), .cmp_neg_act(neg_a), .cmp_one(one_l), .cmp_zero(zero_l),
      .rx_data(rx_data), .bus_busy(bus_busy)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input bit pa, input bit na, input bit o, input bit z);
      pos_a = pa; neg_a = na; one_l = o; zero_l = z;
   endtask

   task automatic settle_idle();
      drive(0, 0, 0, 0);
      for (int i = 0; i < SYNC + IDLE + 4; i++) tick();
   endtask

   task automatic make_busy_low();
      drive(0, 1, 0, 1);
      for (int i = 0; i < SYNC + ACT + 2; i++) tick();
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n;
      bit seen;
      bit bits [64];

      // R8: reset state
      tick(); tick();
      check(rx_data == 1'b1, "R8 rx_data", rx_data, 1);
      check(bus_busy == 1'b0, "R8 bus_busy", bus_busy, 0);
      rst_n = 1'b1;
      op_normal = 1'b1;
      tick();

      // R1: activity latency
      drive(0, 1, 0, 1);
      n = 0;
      while (!bus_busy && n < 50) begin tick(); n++; end
      check(n == SYNC + ACT, "R1 busy latency", n, SYNC + ACT);
      check(rx_data == 1'b0, "R5 rx low at detection", rx_data, 0);

      // R3: idle latency
      drive(0, 0, 0, 0);
      n = 0;
      while (bus_busy && n < 50) begin
         tick(); n++;
         // R6: line held low in band until idle declared
         if (bus_busy) check(rx_data == 1'b0, "R6 hold low", rx_data, 0);
      end
      check(n == SYNC + IDLE, "R3 idle latency", n, SYNC + IDLE);
      check(rx_data == 1'b1, "R3 rx high at idle", rx_data, 1);

      // R2: burst-length sweep
      for (int len = 1; len <= ACT + 2; len++) begin
         settle_idle();
         seen = 0;
         drive(0, 1, 0, 1);
         for (int i = 0; i < len; i++) begin
            tick();
            if (bus_busy || !rx_data) seen = 1;
         end
         drive(0, 0, 0, 0);
         for (int i = 0; i < SYNC + 2; i++) begin
            tick();
            if (bus_busy || !rx_data) seen = 1;
         end
         check(seen == (len >= ACT), "R2 burst sweep", seen, (len >= ACT));
      end

      // R4: gap-length sweep
      for (int gap = 1; gap <= IDLE + 2; gap++) begin
         settle_idle();
         make_busy_low();
         seen = 0;
         drive(0, 0, 0, 0);
         for (int i = 0; i < gap; i++) begin
            tick();
            if (!bus_busy || rx_data) seen = 1;
         end
         drive(0, 1, 0, 1);
         for (int i = 0; i < SYNC + 2; i++) begin
            tick();
            if (!bus_busy || rx_data) seen = 1;
         end
         check(seen == (gap >= IDLE), "R4 gap sweep", seen, (gap >= IDLE));
      end

      // R5: single-cycle bit stream, latency SYNC+1
      settle_idle();
      drive(1, 0, 1, 0);
      for (int i = 0; i < SYNC + ACT + 2; i++) tick();
      check(rx_data == 1'b1 && bus_busy, "R5 busy high", rx_data, 1);
      for (int j = 0; j < 40; j++) begin
         bits[j] = ((j * 5 + j / 3) % 2) == 1;
         drive(bits[j], !bits[j], bits[j], !bits[j]);
         tick();
         if (j >= SYNC) check(rx_data == bits[j - SYNC], "R5 bit follow", rx_data, bits[j - SYNC]);
      end
      // R5: both data levels high, one wins
      drive(1, 0, 1, 1);
      for (int i = 0; i < SYNC + 2; i++) tick();
      check(rx_data == 1'b1, "R5 one priority", rx_data, 1);

      // R6: band hold after a high
      drive(1, 0, 0, 0);
      for (int i = 0; i < SYNC + 3; i++) tick();
      check(rx_data == 1'b1, "R6 hold high", rx_data, 1);
      drive(1, 0, 0, 1);
      for (int i = 0; i < SYNC + 1; i++) tick();
      drive(1, 0, 0, 0);
      for (int i = 0; i < SYNC + 3; i++) tick();
      check(rx_data == 1'b0, "R6 hold low", rx_data, 0);

      // R7: mode drop while busy
      op_normal = 1'b0;
      tick();
      check(rx_data == 1'b1, "R7 rx parked", rx_data, 1);
      check(bus_busy == 1'b0, "R7 busy cleared", bus_busy, 0);
      // R7: live bus outside operating mode
      seen = 0;
      drive(0, 1, 0, 1);
      for (int i = 0; i < 20; i++) begin
         tick();
         if (bus_busy || !rx_data) seen = 1;
      end
      check(seen == 0, "R7 no detection", seen, 0);
      op_normal = 1'b1;
      settle_idle();

      // R9: data comparator ignored while idle
      seen = 0;
      drive(0, 0, 0, 1);
      for (int i = 0; i < 20; i++) begin
         tick();
         if (bus_busy || !rx_data) seen = 1;
      end
      check(seen == 0, "R9 zero ignored idle", seen, 0);
      drive(0, 0, 0, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule